// File: doc/BRIEF.md
# Sectioned Binary Divider Chain

This block is a 24-stage divide-by-two chain that runs on a system clock and counts the falling edges of a slow count input. The count input first passes through a synchronizer and an edge detector. Each detected HIGH-to-LOW transition advances the chain by one. The upper seven stages drive the tap outputs, which give division ratios from 2^18 to 2^24. An asynchronous master reset clears every stage. It takes priority over any count activity.

A test select input cuts the carry links between the three 8-stage sections. Every section then counts the same input pulses in parallel. After 255 pulses all 24 stages are HIGH. The carry links are then restored, and one further pulse rolls the whole chain back to zero. This exercises every stage without waiting for 2^24 pulses.

A full-state port shows all 24 stages so that the chain can be observed in verification.

Top module: `stage_divider`

## Requirements
- R1: In normal mode (test select LOW), each detected falling edge of the count input adds one to the 24-bit full state. The full state wraps modulo 2^24, and the carry crosses the section boundaries.
- R2: Rising edges of the count input and steady levels of the count input leave the full state unchanged.
- R3: Asserting master reset clears all 24 stages to zero at once, without waiting for a clock edge. While master reset stays HIGH, count edges have no effect.
- R4: The tap output bit i equals full-state bit 17+i for i = 0..6, which is stage 18+i counting from stage 1. Tap bit 6 is therefore the most significant stage.
- R5: In test mode (test select HIGH), each detected falling edge adds one to each 8-bit section independently (bits 7:0, 15:8 and 23:16), with no carry between the sections.
- R6: After a master reset, 255 falling edges in test mode leave the full state at 0xFFFFFF.
- R7: In normal mode, one falling edge applied to a full state of 0xFFFFFF returns it to 0x000000.
- R8: Changing the test select alone never alters the stored full state.
- R9: The full state changes on the third rising clock edge after the count input falls, and not on any earlier edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| masterReset | input | 1 | Asynchronous clear, active HIGH |
| countIn | input | 1 | Count input, asynchronous, counted on falling edges |
| testSel | input | 1 | HIGH splits the chain into three parallel 8-stage sections |
| tapOut | output | 7 | Stages 18 through 24 |
| fullState | output | 24 | All stage values, for observation |

## Verification
The bench builds the block with its default shape: three sections of eight stages, seven taps and a two-flop synchronizer. With that shape the test mode loads an equal count into every section. Loading 2, 128 or 255 pulses therefore places known patterns on the upper stages within a few hundred pulses. This puts the tap mapping, the full-chain rollover and the section boundaries within reach of a short run. A 256-pulse run in normal mode covers the carry from the first section into the second.

// File: rtl/stage_divider_pkg.sv
package stage_divider_pkg;

  // Strobes passed from the control to the datapath each cycle
  typedef struct packed {
    logic countStep;      // one-cycle pulse for each detected falling edge
    logic splitSections;  // sections count independently when set
  } divStrobe_t;

endpackage

// File: rtl/stage_divider_ctl.sv
module stage_divider_ctl
  import stage_divider_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       masterReset,
  input  logic       countIn,
  input  logic       testSel,
  output divStrobe_t strobe
);

  // Synchronizer flops plus one history flop for the edge detector
  logic [SYNC_STAGES:0]   countPipe;
  logic [SYNC_STAGES-1:0] modePipe;

  always_ff @(posedge clk or posedge masterReset) begin
    if (masterReset) begin
      countPipe <= '0;
      modePipe  <= '0;
    end else begin
      countPipe <= {countPipe[SYNC_STAGES-1:0], countIn};
      modePipe  <= {modePipe[SYNC_STAGES-2:0], testSel};
    end
  end

  // Falling edge: the older sample is HIGH and the newer sample is LOW
  assign strobe.countStep     = countPipe[SYNC_STAGES] & ~countPipe[SYNC_STAGES-1];
  assign strobe.splitSections = modePipe[SYNC_STAGES-1];

  // R2: one falling edge produces exactly one step
  p_single_step_r2: assert property (@(posedge clk) disable iff (masterReset)
    strobe.countStep |=> !strobe.countStep);

  // R9: a step requires that the input was seen HIGH and then LOW
  p_step_after_high_r9: assert property (@(posedge clk) disable iff (masterReset)
    strobe.countStep |-> $past(countPipe[SYNC_STAGES-1]));

endmodule

// File: rtl/stage_divider_dp.sv
module stage_divider_dp
  import stage_divider_pkg::*;
#(
  parameter int SECTION_W = 8,
  parameter int SECTIONS  = 3,
  localparam int TOTAL    = SECTION_W * SECTIONS
) (
  input  logic             clk,
  input  logic             masterReset,
  input  divStrobe_t       strobe,
  output logic [TOTAL-1:0] stateQ
);

  logic [SECTIONS-1:0] secEn;
  logic [SECTIONS-1:0] secFull;

  // Carry routing: chained in series mode, shared pulse in split mode
  always_comb begin
    logic chainCarry;
    chainCarry = strobe.countStep;
    for (int s = 0; s < SECTIONS; s++) begin
      secEn[s]   = strobe.splitSections ? strobe.countStep : chainCarry;
      chainCarry = secEn[s] & secFull[s];
    end
  end

  for (genvar s = 0; s < SECTIONS; s++) begin : g_section
    logic [SECTION_W-1:0] cntQ;

    always_ff @(posedge clk or posedge masterReset) begin
      if (masterReset)   cntQ <= '0;
      else if (secEn[s]) cntQ <= cntQ + 1'b1;
    end

    assign secFull[s]                      = &cntQ;
    assign stateQ[s*SECTION_W +: SECTION_W] = cntQ;

    // R5: in split mode every section advances by one on a step
    p_section_inc_r5: assert property (@(posedge clk) disable iff (masterReset)
      (strobe.splitSections && strobe.countStep) |=>
        cntQ == SECTION_W'($past(cntQ) + 1'b1));
  end

  // R3: the state is zero whenever master reset is held
  p_clear_r3: assert property (@(posedge clk)
    masterReset |-> stateQ == '0);

  // R2: without a step the state holds
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (masterReset)
    !strobe.countStep |=> $stable(stateQ));

  // R1: in series mode the whole chain advances by one, modulo 2^TOTAL
  p_series_inc_r1: assert property (@(posedge clk) disable iff (masterReset)
    (!strobe.splitSections && strobe.countStep) |=>
      stateQ == TOTAL'($past(stateQ) + 1'b1));

endmodule

// File: rtl/stage_divider.sv
module stage_divider
  import stage_divider_pkg::*;
#(
  parameter int SECTION_W   = 8,
  parameter int SECTIONS    = 3,
  parameter int TAP_COUNT   = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            masterReset,
  input  logic                            countIn,
  input  logic                            testSel,
  output logic [TAP_COUNT-1:0]            tapOut,
  output logic [SECTION_W*SECTIONS-1:0]   fullState
);

  localparam int TOTAL = SECTION_W * SECTIONS;

  divStrobe_t          strobe;
  logic [TOTAL-1:0]    stateQ;

  stage_divider_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk        (clk),
    .masterReset(masterReset),
    .countIn    (countIn),
    .testSel    (testSel),
    .strobe     (strobe)
  );

  stage_divider_dp #(.SECTION_W(SECTION_W), .SECTIONS(SECTIONS)) u_dp (
    .clk        (clk),
    .masterReset(masterReset),
    .strobe     (strobe),
    .stateQ     (stateQ)
  );

  assign tapOut    = stateQ[TOTAL-1 -: TAP_COUNT];
  assign fullState = stateQ;

endmodule

// File: tb/stage_divider_test.sv
`timescale 1ns/1ps
module stage_divider_test;

  logic        clk = 1'b0;
  logic        masterReset = 1'b1;
  logic        countIn = 1'b0;
  logic        testSel = 1'b0;
  logic [6:0]  tapOut;
  logic [23:0] fullState;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  stage_divider uut (
    .clk(clk), .masterReset(masterReset), .countIn(countIn),
    .testSel(testSel), .tapOut(tapOut), .fullState(fullState)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) countIn = 1'b1;
      repeat (4) @(negedge clk);
      countIn = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic doReset();
    @(negedge clk) masterReset = 1'b1;
    repeat (2) @(negedge clk);
    masterReset = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic setMode(input logic m);
    @(negedge clk) testSel = m;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    check("R3 reset full", fullState, 0);
    check("R3 reset taps", tapOut, 0);
  endtask

  task automatic t_edges();
    doReset();
    @(negedge clk) countIn = 1'b1;
    repeat (6) @(negedge clk);
    check("R2 rising edge ignored", fullState, 0);
    countIn = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 no change after two edges", fullState, 0);
    @(negedge clk);
    check("R9 change on third edge", fullState, 1);
    repeat (10) @(negedge clk);
    check("R2 steady low ignored", fullState, 1);
  endtask

  task automatic t_series();
    doReset();
    pulse(255);
    check("R1 count 255", fullState, 24'h0000FF);
    pulse(1);
    check("R1 carry into second section", fullState, 24'h000100);
    check("R4 taps low count", tapOut, 0);
  endtask

  task automatic t_split();
    doReset();
    setMode(1'b1);
    pulse(3);
    check("R5 parallel sections", fullState, 24'h030303);
    setMode(1'b0);
    check("R8 mode to series keeps state", fullState, 24'h030303);
    setMode(1'b1);
    check("R8 mode to split keeps state", fullState, 24'h030303);
    setMode(1'b0);
  endtask

  task automatic t_taps();
    doReset();
    setMode(1'b1);
    pulse(2);
    setMode(1'b0);
    check("R4 full 020202", fullState, 24'h020202);
    check("R4 tap stage18", tapOut, 7'h01);
    doReset();
    setMode(1'b1);
    pulse(128);
    setMode(1'b0);
    check("R4 tap stage24", tapOut, 7'h40);
  endtask

  task automatic t_fill_rollover();
    doReset();
    setMode(1'b1);
    pulse(255);
    check("R6 all stages high", fullState, 24'hFFFFFF);
    check("R6 taps high", tapOut, 7'h7F);
    setMode(1'b0);
    check("R8 fill kept on mode change", fullState, 24'hFFFFFF);
    pulse(1);
    check("R7 rollover to zero", fullState, 0);
    check("R7 taps zero", tapOut, 0);
  endtask

  task automatic t_mid_reset();
    doReset();
    pulse(5);
    check("R1 count five", fullState, 5);
    @(negedge clk) masterReset = 1'b1;
    #2;
    check("R3 asynchronous clear", fullState, 0);
    countIn = 1'b1;
    repeat (4) @(negedge clk);
    countIn = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 override during reset", fullState, 0);
    masterReset = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 zero after release", fullState, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    masterReset = 1'b0;
    repeat (2) @(negedge clk);
    t_reset_state();
    t_edges();
    t_series();
    t_split();
    t_taps();
    t_fill_rollover();
    t_mid_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule